// File: doc/BRIEF.md
# Two-Register Circular Address Generator

This block produces addresses for a circular buffer using only two pieces of state: the current pointer and one shape register. The shape register holds either a mask or a buffer length, depending on a mode bit loaded with it. The address is split into an upper part that never moves and a lower field that counts up or down by one and wraps.

In mask mode the buffer length is a power of two, and the buffer is aligned to that size. The highest set bit of the shape value sets the split point. Every bit at or below that position belongs to the wrapping lower field. In modulo mode the shape value is a length L. The buffer takes the smallest power-of-two region that holds L entries, but the lower field wraps between 0 and L-1. For example, L = 366 reserves 512 words and steps only through 0..365.

A host loads the pointer and the shape, then issues step requests with a direction bit. The registered pointer is the address output.

Top module: `modptr_gen`

## Requirements
- R1: After reset the address is 0 and the block is in mask mode with an all-ones mask, so a step up from reset gives address 1.
- R2: A pointer load replaces the whole address on the next clock edge. It takes priority over a step requested in the same cycle.
- R3: In mask mode (mode bit 0) a step up increments the lower field. The lower field wraps from all-ones to 0, and bits above the split never change.
- R4: In mask mode a step down from a lower field of 0 gives an all-ones lower field. The upper bits are unchanged.
- R5: In mask mode the split is set only by the highest set bit of the mask value. Mask 0x0024 behaves exactly like mask 0x003F.
- R6: In modulo mode (mode bit 1) with length L, the lower field is the smallest power-of-two field that holds L values, and the bits above it never change on a step. With L = 8 the field is 3 bits wide.
- R7: In modulo mode a step up from lower value L-1, or from any lower value at or above L-1, gives lower value 0. Otherwise it adds 1.
- R8: In modulo mode a step down from lower value 0 gives L-1. Otherwise it subtracts 1.
- R9: A shape load does not move the address. A step in the same cycle as a shape load uses the previous shape and mode, and the new ones apply from the next step.
- R10: With no step and no pointer load, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_load | input | 1 | Load `ptr_val` into the pointer |
| ptr_val | input | AW | New pointer value |
| shape_load | input | 1 | Load `shape_val` and `shape_mode` |
| shape_mode | input | 1 | 0 = mask mode, 1 = modulo mode |
| shape_val | input | AW | Mask (mask mode) or length (modulo mode) |
| step_en | input | 1 | Advance the pointer one position |
| step_dn | input | 1 | Direction of the step: 0 = up, 1 = down |
| addr | output | AW | Current circular address |

## Verification
The bench targets the wrap points, which are the places this block is most likely to go wrong:
- A modulo length that is not a power of two, stepped both ways across 0 and L-1. A design that simply masked bits would go past 365 to 366.
- A modulo length that is exactly a power of two. An off-by-one in the field-size derivation would double the region and break the wrap.
- A pointer loaded with a lower value above L-1. A design that compared only for equality would run on to the end of the power-of-two region.
- A sparse mask and a shape load in the same cycle as a step. A design that used the raw mask, or that let a new shape act at once, would give a different lower field.

// File: rtl/modptr_pkg.sv
package modptr_pkg;

   typedef enum logic {
      WRAP_MASK    = 1'b0,
      WRAP_MODULO  = 1'b1
   } wrap_mode_e;

endpackage

// File: rtl/modptr_span.sv
// Derives the lower-field mask and the last valid lower value from the shape register.
module modptr_span
   import modptr_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW-1:0] shape,
   input  wrap_mode_e    mode,
   output logic [AW-1:0] span_mask,
   output logic [AW-1:0] bound
);

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] seed;

   // Modulo mode sizes the region from L-1 so that an exact power of two is not doubled.
   assign seed = (mode == WRAP_MODULO) ? (shape - ONE) : shape;

   // Fill every bit below the highest set bit of the seed.
   assign span_mask[AW-1] = seed[AW-1];
   for (genvar i = AW - 2; i >= 0; i--) begin : g_smear
      assign span_mask[i] = span_mask[i+1] | seed[i];
   end

   assign bound = (mode == WRAP_MODULO) ? (shape - ONE) : span_mask;

endmodule

// File: rtl/modptr_step.sv
// Next pointer for a single step up or down inside the lower field.
module modptr_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] span_mask,
   input  logic [AW-1:0] bound,
   input  logic          dir_dn,
   output logic [AW-1:0] ptr_next
);

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] lo;
   logic [AW-1:0] lo_up;
   logic [AW-1:0] lo_dn;
   logic [AW-1:0] lo_new;

   assign lo     = ptr & span_mask;
   assign lo_up  = (lo >= bound) ? '0 : (lo + ONE);
   assign lo_dn  = (lo == '0) ? bound : (lo - ONE);
   assign lo_new = dir_dn ? lo_dn : lo_up;

   assign ptr_next = (ptr & ~span_mask) | (lo_new & span_mask);

endmodule

// File: rtl/modptr_gen.sv
module modptr_gen
   import modptr_pkg::*;
#(
   parameter int            AW        = 16,
   parameter logic [AW-1:0] RESET_PTR = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_load,
   input  logic [AW-1:0] ptr_val,
   input  logic          shape_load,
   input  logic          shape_mode,
   input  logic [AW-1:0] shape_val,
   input  logic          step_en,
   input  logic          step_dn,
   output logic [AW-1:0] addr
);

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("modptr_gen: AW must lie in 2..32");
   end

   logic [AW-1:0] ptr_q;
   logic [AW-1:0] shape_q;
   wrap_mode_e    mode_q;
   logic [AW-1:0] span_mask;
   logic [AW-1:0] bound;
   logic [AW-1:0] ptr_next;

   modptr_span #(.AW(AW)) u_span (
      .shape     (shape_q),
      .mode      (mode_q),
      .span_mask (span_mask),
      .bound     (bound)
   );

   modptr_step #(.AW(AW)) u_step (
      .ptr       (ptr_q),
      .span_mask (span_mask),
      .bound     (bound),
      .dir_dn    (step_dn),
      .ptr_next  (ptr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= RESET_PTR;
      end else if (ptr_load) begin
         ptr_q <= ptr_val;
      end else if (step_en) begin
         ptr_q <= ptr_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shape_q <= '1;
         mode_q  <= WRAP_MASK;
      end else if (shape_load) begin
         shape_q <= shape_val;
         mode_q  <= wrap_mode_e'(shape_mode);
      end
   end

   assign addr = ptr_q;

endmodule

// File: rtl/modptr_chk.sv
module modptr_chk
   import modptr_pkg::*;
#(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ptr_load,
   input logic [AW-1:0] ptr_val,
   input logic          step_en,
   input logic          step_dn,
   input logic [AW-1:0] addr,
   input logic [AW-1:0] span_mask,
   input logic [AW-1:0] shape_q,
   input wrap_mode_e    mode_q
);

   localparam logic [AW-1:0] ONE = AW'(1);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !ptr_load) |=> $stable(addr)); // R10

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load |=> (addr == $past(ptr_val))); // R2

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ptr_load) |=>
         ((addr & ~$past(span_mask)) == ($past(addr) & ~$past(span_mask)))); // R6

   AST_MOD_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_dn && !ptr_load && mode_q == WRAP_MODULO &&
       ((addr & span_mask) == (shape_q - ONE)))
      |=> ((addr & $past(span_mask)) == '0)); // R7

   AST_MOD_BOTTOM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_dn && !ptr_load && mode_q == WRAP_MODULO &&
       ((addr & span_mask) == '0))
      |=> ((addr & $past(span_mask)) == ($past(shape_q) - ONE))); // R8

endmodule

bind modptr_gen modptr_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptr_load  (ptr_load),
   .ptr_val   (ptr_val),
   .step_en   (step_en),
   .step_dn   (step_dn),
   .addr      (addr),
   .span_mask (span_mask),
   .shape_q   (shape_q),
   .mode_q    (mode_q)
);

// File: tb/tb_modptr_gen.sv
`timescale 1ns/1ps
module tb_modptr_gen;

   localparam int AW = 16;
   // Vector: {op[2:0], mode, value[15:0], expected[15:0], req[3:0]}
   // op: 0 idle, 1 pointer load, 2 shape load, 3 step up, 4 step down
   localparam int NV = 29;
   localparam logic [39:0] VEC [NV] = '{
      {3'd3, 1'b0, 16'h0000, 16'h0001, 4'd1},  // R1 full-width counter from reset
      {3'd1, 1'b0, 16'h1234, 16'h1234, 4'd2},  // R2
      {3'd2, 1'b0, 16'h003F, 16'h1234, 4'd9},  // R9 shape load alone
      {3'd1, 1'b0, 16'h123E, 16'h123E, 4'd2},  // R2
      {3'd3, 1'b0, 16'h0000, 16'h123F, 4'd3},  // R3
      {3'd3, 1'b0, 16'h0000, 16'h1200, 4'd3},  // R3 wrap
      {3'd4, 1'b0, 16'h0000, 16'h123F, 4'd4},  // R4
      {3'd0, 1'b0, 16'h0000, 16'h123F, 4'd10}, // R10
      {3'd2, 1'b0, 16'h0024, 16'h123F, 4'd9},  // R9
      {3'd3, 1'b0, 16'h0000, 16'h1200, 4'd5},  // R5 sparse mask
      {3'd2, 1'b1, 16'h016E, 16'h1200, 4'd9},  // R9 length 366
      {3'd1, 1'b0, 16'h4200, 16'h4200, 4'd2},  // R2
      {3'd4, 1'b0, 16'h0000, 16'h436D, 4'd8},  // R8
      {3'd3, 1'b0, 16'h0000, 16'h4200, 4'd7},  // R7
      {3'd3, 1'b0, 16'h0000, 16'h4201, 4'd7},  // R7
      {3'd1, 1'b0, 16'h436C, 16'h436C, 4'd2},  // R2
      {3'd3, 1'b0, 16'h0000, 16'h436D, 4'd7},  // R7
      {3'd3, 1'b0, 16'h0000, 16'h4200, 4'd6},  // R6 no run to 366
      {3'd1, 1'b0, 16'h43F0, 16'h43F0, 4'd2},  // R2
      {3'd3, 1'b0, 16'h0000, 16'h4200, 4'd7},  // R7 above bound
      {3'd2, 1'b1, 16'h0005, 16'h4200, 4'd9},  // R9 length 5
      {3'd1, 1'b0, 16'hABC4, 16'hABC4, 4'd2},  // R2
      {3'd3, 1'b0, 16'h0000, 16'hABC0, 4'd7},  // R7
      {3'd4, 1'b0, 16'h0000, 16'hABC4, 4'd8},  // R8
      {3'd2, 1'b1, 16'h0008, 16'hABC4, 4'd9},  // R9 length 8
      {3'd1, 1'b0, 16'hABC7, 16'hABC7, 4'd2},  // R2
      {3'd3, 1'b0, 16'h0000, 16'hABC0, 4'd6},  // R6 exact power of two
      {3'd4, 1'b0, 16'h0000, 16'hABC7, 4'd8},  // R8
      {3'd3, 1'b0, 16'h0000, 16'hABC0, 4'd6}   // R6
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ptr_load = 1'b0;
   logic [AW-1:0] ptr_val = '0;
   logic          shape_load = 1'b0;
   logic          shape_mode = 1'b0;
   logic [AW-1:0] shape_val = '0;
   logic          step_en = 1'b0;
   logic          step_dn = 1'b0;
   logic [AW-1:0] addr;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   modptr_gen #(.AW(AW)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptr_load   (ptr_load),
      .ptr_val    (ptr_val),
      .shape_load (shape_load),
      .shape_mode (shape_mode),
      .shape_val  (shape_val),
      .step_en    (step_en),
      .step_dn    (step_dn),
      .addr       (addr)
   );

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: addr=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      ptr_load = 1'b0; shape_load = 1'b0; step_en = 1'b0; step_dn = 1'b0;
   endtask

   task automatic apply(input logic [2:0] op, input logic md, input logic [AW-1:0] val);
      @(negedge clk);
      clear_inputs();
      case (op)
         3'd1: begin ptr_load = 1'b1; ptr_val = val; end
         3'd2: begin shape_load = 1'b1; shape_mode = md; shape_val = val; end
         3'd3: begin step_en = 1'b1; step_dn = 1'b0; end
         3'd4: begin step_en = 1'b1; step_dn = 1'b1; end
         default: ;
      endcase
      @(posedge clk);
      #1;
      clear_inputs();
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", addr, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][39:37], VEC[i][36], VEC[i][35:20]);
         check($sformatf("R%0d vec%0d", VEC[i][3:0], i), addr, VEC[i][19:4]);
      end

      // R10: several idle cycles
      repeat (4) apply(3'd0, 1'b0, '0);
      check("R10 idle run", addr, 16'hABC0);

      // R2: pointer load beats a simultaneous step
      @(negedge clk);
      ptr_load = 1'b1; ptr_val = 16'h5555; step_en = 1'b1;
      @(posedge clk); #1; clear_inputs();
      check("R2 load priority", addr, 16'h5555);

      // R1: reset during operation restores full mask and zero address
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      check("R1 reset mid-run", addr, 16'h0000);
      @(negedge clk); rst_n = 1'b1;

      // R9: step in the same cycle as a shape load uses the old full mask
      apply(3'd1, 1'b0, 16'h00FF);
      @(negedge clk);
      shape_load = 1'b1; shape_mode = 1'b0; shape_val = 16'h000F; step_en = 1'b1;
      @(posedge clk); #1; clear_inputs();
      check("R9 old shape on same-cycle step", addr, 16'h0100);
      apply(3'd4, 1'b0, '0);
      check("R9 new shape next step", addr, 16'h010F);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule